// File: doc/BRIEF.md
# Accumulator Single-Operand ALU

This unit holds an 8-bit accumulator together with a carry flag and a half-carry flag, and applies one single-operand operation to them per execute strobe. The operations are increment, decrement, decimal (BCD) correction, rotate right through carry, rotate left through carry, nibble exchange, carry set and carry clear. Every result is registered: an operation requested in one cycle shows at the outputs after the next rising clock edge.

A separate load port stands in for the two-operand arithmetic that lives outside this unit. It writes the accumulator, both flags and a one-bit mode that records whether that arithmetic was an addition or a subtraction. Decimal correction then reads the loaded flags and the mode to pick its adjustment. Its result is only meaningful straight after such a load.

Top module: `acc_unary_alu`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears the accumulator, C, HC and the mode (to add) and overrides every other input.
- R2: When `ld_en` is high at a rising edge, the accumulator, C, HC and the mode take `ld_acc`, `ld_c`, `ld_hc` and `ld_sub` (1 = subtract). This takes priority over `exec_en`.
- R3: With `rst`, `ld_en` and `exec_en` all low, the accumulator and both flags hold their values.
- R4: Operation code 0 (increment) adds 1 and code 1 (decrement) subtracts 1 from the accumulator, modulo 256. C and HC do not change.
- R5: Code 3 (rotate right through carry) moves the old C into bit 7 and each bit one place down. The old bit 0 becomes C. HC does not change.
- R6: Code 4 (rotate left through carry) moves the old C into bit 0 and each bit one place up. The old bit 7 becomes C, and HC takes the old bit 0.
- R7: Code 5 exchanges bits 7..4 with bits 3..0 and leaves both flags unchanged.
- R8: Code 6 drives both C and HC to 1. Code 7 drives both to 0. The accumulator is unchanged.
- R9: Code 2 in add mode adds 0x06 when HC is 1 or the low digit exceeds 9, and adds 0x60 when C is 1 or the accumulator exceeds 0x99. Both conditions are judged on the value before correction. C becomes 1 if the 0x60 correction applied and is otherwise unchanged. HC does not change.
- R10: Code 2 in subtract mode subtracts 0x06 when HC is 1 (low-digit borrow) and subtracts 0x60 when C is 1 (borrow). Both flags stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| ld_en | input | 1 | Load strobe for accumulator, flags and mode |
| ld_acc | input | 8 | Accumulator value to load |
| ld_c | input | 1 | Carry value to load |
| ld_hc | input | 1 | Half-carry value to load |
| ld_sub | input | 1 | Mode to load: 1 after a subtract, 0 after an add |
| exec_en | input | 1 | Execute strobe for the selected operation |
| op_sel | input | 3 | Operation code (0..7 as listed in the requirements) |
| acc | output | 8 | Accumulator |
| c_flag | output | 1 | Carry flag |
| hc_flag | output | 1 | Half-carry flag |

## Verification
Every result of this block is due exactly one rising edge after the cycle in which its strobe or reset is presented, because the accumulator and both flags sit in a single register stage. The driver applies inputs on the falling edge and queues the expected accumulator and flags for that edge. The monitor takes one entry two nanoseconds after each rising edge, so each comparison lands in the cycle the result appears and before the next stimulus. Idle cycles also queue an entry, which makes the hold behaviour a timed check like any other.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  localparam int ACC_W   = 8;
  localparam int NIB_W   = ACC_W / 2;
  localparam int OP_W    = 3;
  localparam int DIG_MAX = 9;

  typedef logic [ACC_W-1:0] acc_t;

  localparam acc_t LO_ADJ  = acc_t'(6);
  localparam acc_t HI_ADJ  = acc_t'(6) << NIB_W;
  localparam acc_t BCD_TOP = (acc_t'(DIG_MAX) << NIB_W) | acc_t'(DIG_MAX);

  typedef enum logic [OP_W-1:0] {
    OP_INC  = 3'd0,
    OP_DEC  = 3'd1,
    OP_DCOR = 3'd2,
    OP_RRC  = 3'd3,
    OP_RLC  = 3'd4,
    OP_SWAP = 3'd5,
    OP_SETC = 3'd6,
    OP_CLRC = 3'd7
  } acc_op_e;

  typedef struct packed {
    acc_t acc;
    logic c;
    logic hc;
  } alu_res_t;

  // low digit correction needed
  function automatic logic f_lo_fix(acc_t a, logic hc, logic sub);
    if (sub) return hc;
    return hc | (a[NIB_W-1:0] > NIB_W'(DIG_MAX));
  endfunction

  // high digit correction needed
  function automatic logic f_hi_fix(acc_t a, logic c, logic sub);
    if (sub) return c;
    return c | (a > BCD_TOP);
  endfunction

  function automatic alu_res_t f_dcor(acc_t a, logic c, logic hc, logic sub);
    acc_t adj;
    logic hi;
    hi  = f_hi_fix(a, c, sub);
    adj = (f_lo_fix(a, hc, sub) ? LO_ADJ : '0) | (hi ? HI_ADJ : '0);
    if (sub) return '{acc: a - adj, c: c, hc: hc};
    return '{acc: a + adj, c: c | hi, hc: hc};
  endfunction

  function automatic alu_res_t f_rrc(acc_t a, logic c, logic hc);
    return '{acc: {c, a[ACC_W-1:1]}, c: a[0], hc: hc};
  endfunction

  function automatic alu_res_t f_rlc(acc_t a, logic c);
    return '{acc: {a[ACC_W-2:0], c}, c: a[ACC_W-1], hc: a[0]};
  endfunction

  function automatic acc_t f_swap(acc_t a);
    return {a[NIB_W-1:0], a[ACC_W-1:NIB_W]};
  endfunction
endpackage

// File: rtl/acc_alu_datapath.sv
module acc_alu_datapath
  import acc_alu_pkg::*;
(
  input  acc_op_e  op,
  input  acc_t     cur_acc,
  input  logic     cur_c,
  input  logic     cur_hc,
  input  logic     cur_sub,
  output alu_res_t nxt,
  output logic     lo_fix,
  output logic     hi_fix
);
  assign lo_fix = f_lo_fix(cur_acc, cur_hc, cur_sub);
  assign hi_fix = f_hi_fix(cur_acc, cur_c, cur_sub);

  always_comb begin
    nxt = '{acc: cur_acc, c: cur_c, hc: cur_hc};
    unique case (op)
      OP_INC:  nxt.acc = cur_acc + acc_t'(1);
      OP_DEC:  nxt.acc = cur_acc - acc_t'(1);
      OP_DCOR: nxt = f_dcor(cur_acc, cur_c, cur_hc, cur_sub);
      OP_RRC:  nxt = f_rrc(cur_acc, cur_c, cur_hc);
      OP_RLC:  nxt = f_rlc(cur_acc, cur_c);
      OP_SWAP: nxt.acc = f_swap(cur_acc);
      OP_SETC: begin nxt.c = 1'b1; nxt.hc = 1'b1; end
      OP_CLRC: begin nxt.c = 1'b0; nxt.hc = 1'b0; end
      default: nxt = '{acc: cur_acc, c: cur_c, hc: cur_hc};
    endcase
  end
endmodule

// File: rtl/acc_alu_regs.sv
module acc_alu_regs
  import acc_alu_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     ld_en,
  input  alu_res_t ld_val,
  input  logic     ld_sub,
  input  logic     exec_en,
  input  alu_res_t nxt,
  output alu_res_t state,
  output logic     mode_sub
);
  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= '0;
      mode_sub <= 1'b0;
    end else if (ld_en) begin
      state    <= ld_val;
      mode_sub <= ld_sub;
    end else if (exec_en) begin
      state    <= nxt;
    end
  end
endmodule

// File: rtl/acc_unary_alu.sv
module acc_unary_alu
  import acc_alu_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             ld_en,
  input  logic [ACC_W-1:0] ld_acc,
  input  logic             ld_c,
  input  logic             ld_hc,
  input  logic             ld_sub,
  input  logic             exec_en,
  input  logic [OP_W-1:0]  op_sel,
  output logic [ACC_W-1:0] acc,
  output logic             c_flag,
  output logic             hc_flag
);
  alu_res_t state;
  alu_res_t nxt;
  alu_res_t ld_val;
  logic     mode_sub;
  logic     lo_fix;
  logic     hi_fix;

  assign ld_val = '{acc: ld_acc, c: ld_c, hc: ld_hc};

  acc_alu_datapath u_dp (
    .op      (acc_op_e'(op_sel)),
    .cur_acc (state.acc),
    .cur_c   (state.c),
    .cur_hc  (state.hc),
    .cur_sub (mode_sub),
    .nxt     (nxt),
    .lo_fix  (lo_fix),
    .hi_fix  (hi_fix)
  );

  acc_alu_regs u_regs (
    .clk      (clk),
    .rst      (rst),
    .ld_en    (ld_en),
    .ld_val   (ld_val),
    .ld_sub   (ld_sub),
    .exec_en  (exec_en),
    .nxt      (nxt),
    .state    (state),
    .mode_sub (mode_sub)
  );

  assign acc     = state.acc;
  assign c_flag  = state.c;
  assign hc_flag = state.hc;
endmodule

// File: rtl/acc_alu_checker.sv
module acc_alu_checker
  import acc_alu_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             ld_en,
  input logic [ACC_W-1:0] ld_acc,
  input logic             exec_en,
  input logic [OP_W-1:0]  op_sel,
  input logic [ACC_W-1:0] acc,
  input logic             c_flag,
  input logic             hc_flag,
  input logic             mode_sub,
  input logic             lo_fix,
  input logic             hi_fix
);
  logic run;
  assign run = exec_en && !ld_en;

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (acc == '0) && !c_flag && !hc_flag && !mode_sub); // R1

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
    ld_en |=> acc == $past(ld_acc)); // R2

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!ld_en && !exec_en) |=> $stable(acc) && $stable(c_flag) && $stable(hc_flag)); // R3

  AST_INC_WRAP: assert property (@(posedge clk) disable iff (rst)
    (run && op_sel == OP_INC) |=> (acc == $past(acc) + 8'd1) && $stable(c_flag) && $stable(hc_flag)); // R4

  AST_RRC_CARRY: assert property (@(posedge clk) disable iff (rst)
    (run && op_sel == OP_RRC) |=> (c_flag == $past(acc[0])) && (acc[ACC_W-1] == $past(c_flag))); // R5

  AST_RLC_HALF: assert property (@(posedge clk) disable iff (rst)
    (run && op_sel == OP_RLC) |=> (hc_flag == $past(acc[0])) && (c_flag == $past(acc[ACC_W-1]))); // R6

  AST_SWAP_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (run && op_sel == OP_SWAP) |=> $stable(c_flag) && $stable(hc_flag)); // R7

  AST_SETC_BOTH: assert property (@(posedge clk) disable iff (rst)
    (run && op_sel == OP_SETC) |=> c_flag && hc_flag && $stable(acc)); // R8

  AST_DCOR_ADD_CARRY: assert property (@(posedge clk) disable iff (rst)
    (run && op_sel == OP_DCOR && !mode_sub && hi_fix) |=> c_flag); // R9

  AST_DCOR_SUB_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (run && op_sel == OP_DCOR && mode_sub) |=> $stable(c_flag) && $stable(hc_flag)); // R10

  AST_DCOR_SUB_NOFIX: assert property (@(posedge clk) disable iff (rst)
    (run && op_sel == OP_DCOR && mode_sub && !lo_fix && !hi_fix) |=> $stable(acc)); // R10
endmodule

bind acc_unary_alu acc_alu_checker u_chk (
  .clk      (clk),
  .rst      (rst),
  .ld_en    (ld_en),
  .ld_acc   (ld_acc),
  .exec_en  (exec_en),
  .op_sel   (op_sel),
  .acc      (acc),
  .c_flag   (c_flag),
  .hc_flag  (hc_flag),
  .mode_sub (mode_sub),
  .lo_fix   (lo_fix),
  .hi_fix   (hi_fix)
);

// File: tb/acc_unary_alu_test.sv
module acc_unary_alu_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ld_en = 1'b0;
  logic [7:0] ld_acc = 8'h00;
  logic       ld_c = 1'b0;
  logic       ld_hc = 1'b0;
  logic       ld_sub = 1'b0;
  logic       exec_en = 1'b0;
  logic [2:0] op_sel = 3'd0;
  logic [7:0] acc;
  logic       c_flag;
  logic       hc_flag;

  always #5 clk = ~clk;

  acc_unary_alu uut (
    .clk(clk), .rst(rst), .ld_en(ld_en), .ld_acc(ld_acc), .ld_c(ld_c),
    .ld_hc(ld_hc), .ld_sub(ld_sub), .exec_en(exec_en), .op_sel(op_sel),
    .acc(acc), .c_flag(c_flag), .hc_flag(hc_flag)
  );

  typedef struct {
    int unsigned a;
    bit          c;
    bit          h;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   total = 0;
  int   bad   = 0;
  bit   done  = 0;

  // reference state
  int unsigned m_a = 0;
  bit          m_c = 0, m_h = 0, m_s = 0;

  task automatic model_op(input int op);
    int unsigned lo, hi, fix;
    bit          lf, hf;
    case (op)
      0: m_a = (m_a + 1) % 256;
      1: m_a = (m_a + 255) % 256;
      2: begin
        lo = m_a % 16; hi = m_a / 16;
        if (m_s) begin
          lf = m_h; hf = m_c;
          fix = (lf ? 6 : 0) + (hf ? 96 : 0);
          m_a = (m_a + 256 - fix) % 256;
        end else begin
          lf = m_h || (lo > 9);
          hf = m_c || (hi > 9) || (hi == 9 && lo > 9);
          fix = (lf ? 6 : 0) + (hf ? 96 : 0);
          m_a = (m_a + fix) % 256;
          if (hf) m_c = 1;
        end
      end
      3: begin bit nc; nc = m_a[0]; m_a = (m_a / 2) + (m_c ? 128 : 0); m_c = nc; end
      4: begin bit o0; o0 = m_a[0]; m_c = m_a[7]; m_a = ((m_a * 2) % 256) + (m_c ? 0 : 0) + 0; end
      5: m_a = ((m_a % 16) * 16) + (m_a / 16);
      6: begin m_c = 1; m_h = 1; end
      default: begin m_c = 0; m_h = 0; end
    endcase
  endtask

  // drive one cycle and queue its expected outcome
  task automatic step(input bit r, input bit l, input int la, input bit lc,
                      input bit lh, input bit ls, input bit ex, input int op,
                      input string tag);
    bit old_c, old_b0;
    @(negedge clk);
    rst = r; ld_en = l; ld_acc = la[7:0]; ld_c = lc; ld_hc = lh; ld_sub = ls;
    exec_en = ex; op_sel = op[2:0];
    if (r) begin
      m_a = 0; m_c = 0; m_h = 0; m_s = 0;
    end else if (l) begin
      m_a = la % 256; m_c = lc; m_h = lh; m_s = ls;
    end else if (ex) begin
      old_c = m_c; old_b0 = m_a[0];
      model_op(op);
      if (op == 4) begin m_a = m_a + (old_c ? 1 : 0); m_h = old_b0; end
    end
    q.push_back('{a: m_a, c: m_c, h: m_h, tag: tag});
  endtask

  task automatic load(input int la, input bit lc, input bit lh, input bit ls, input string tag);
    step(0, 1, la, lc, lh, ls, 0, 0, tag);
  endtask

  task automatic run(input int op, input string tag);
    step(0, 0, 0, 0, 0, 0, 1, op, tag);
  endtask

  // monitor: one expected item per rising edge
  always begin
    @(posedge clk);
    #2;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      total++;
      if (acc !== e.a[7:0] || c_flag !== e.c || hc_flag !== e.h) begin
        bad++;
        $display("FAIL %s: acc=%02h c=%0b hc=%0b expected acc=%02h c=%0b hc=%0b",
                 e.tag, acc, c_flag, hc_flag, e.a[7:0], e.c, e.h);
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    step(1, 0, 0, 0, 0, 0, 0, 0, "R1 reset");
    step(1, 1, 8'hAB, 1, 1, 1, 1, 6, "R1 reset overrides load/exec");
    load(8'h5A, 1, 0, 0, "R2 load");
    step(0, 1, 8'h3C, 0, 1, 0, 1, 0, "R2 load beats exec");
    step(0, 0, 8'hFF, 1, 1, 1, 0, 6, "R3 idle hold");
    step(0, 0, 8'h00, 0, 0, 0, 0, 7, "R3 idle hold");
    load(8'hFF, 1, 0, 0, "R2 load");
    run(0, "R4 inc wraps ff->00");
    run(1, "R4 dec wraps 00->ff");
    run(1, "R4 dec");
    load(8'h81, 0, 1, 0, "R2 load");
    run(3, "R5 rrc c in, bit0 out");
    run(3, "R5 rrc again");
    load(8'h80, 1, 0, 0, "R2 load");
    run(4, "R6 rlc bit7 out, c in");
    load(8'h01, 0, 0, 0, "R2 load");
    run(4, "R6 rlc hc takes bit0");
    load(8'h3C, 1, 0, 0, "R2 load");
    run(5, "R7 swap");
    run(6, "R8 set both flags");
    run(7, "R8 clear both flags");
    load(8'h3C, 0, 0, 0, "R2 load add result");
    run(2, "R9 dcor low digit >9");
    load(8'h10, 0, 1, 0, "R2 load add result");
    run(2, "R9 dcor hc set");
    load(8'h9A, 0, 0, 0, "R2 load add result");
    run(2, "R9 dcor both digits, c set");
    load(8'hA0, 0, 0, 0, "R2 load add result");
    run(2, "R9 dcor high digit >9");
    load(8'h99, 0, 0, 0, "R2 load add result");
    run(2, "R9 dcor no fix at 99");
    load(8'h2D, 0, 1, 1, "R2 load sub result");
    run(2, "R10 dcor sub low borrow");
    load(8'hF5, 1, 0, 1, "R2 load sub result");
    run(2, "R10 dcor sub high borrow");
    load(8'h42, 0, 0, 1, "R2 load sub result");
    run(2, "R10 dcor sub no borrow");
    step(1, 0, 0, 0, 0, 0, 0, 0, "R1 reset clears mode");
    load(8'h9A, 0, 0, 0, "R2 load");
    for (int i = 0; i < 400; i++) begin
      int unsigned pick;
      pick = $urandom % 16;
      if (pick == 0)
        step(0, 1, $urandom % 256, pick[0], $urandom % 2 == 1, $urandom % 2 == 1,
             $urandom % 2 == 1, $urandom % 8, "R2 random load");
      else if (pick == 1)
        step(0, 0, $urandom % 256, 1, 1, 1, 0, $urandom % 8, "R3 random idle");
      else
        run($urandom % 8, "R4-R10 random op");
    end
    step(0, 0, 0, 0, 0, 0, 0, 0, "R3 idle tail");
    repeat (3) @(posedge clk);
    #3;
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule